// File: doc/BRIEF.md
# Radix-Tree Page Table Walker

This block resolves a virtual address into a physical frame after the translation cache misses. A miss request carries the virtual address and whether the walk uses four or five table levels. Starting from a root table frame supplied on an input, the walker reads one 8-byte entry per level. Each level is a 4 KB table of 512 entries, indexed by a 9-bit slice of the virtual address. The walk moves strictly downward through the levels.

The walk ends in one of three ways. An entry with its present bit clear ends it with a fault. An entry with its page-size bit set at the 1 GB or 2 MB level ends it early with a huge mapping. An entry found at the lowest level gives a 4 KB mapping. On success the walker emits a one-cycle fill carrying the frame number of the 4 KB page that contains the address, together with a size code, so the translation cache can install the entry. Only one walk is in flight at a time. Memory reads go through a valid/ready request port and a response port that returns one word per request.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `miss_ready` is 1, and `mem_req_valid`, `fill_valid` and `fault_valid` are 0.
- R2: A miss is accepted only while `miss_ready` is 1. A `miss_valid` pulse during a walk is ignored: it changes neither the reads nor the result of the current walk, and it starts no walk afterwards.
- R3: The first read address is `root_frame`*4096 + 8*top index. The top index is VA[47:39] in four-level mode and VA[56:48] in five-level mode.
- R4: Each later read address is entry[51:12]*4096 + 8*index. The indices are taken in order VA[47:39], VA[38:30], VA[29:21], VA[20:12], with one read per level and never more than 4 (four-level) or 5 (five-level) reads per walk.
- R5: A response with bit 0 (present) clear ends the walk with a one-cycle `fault_valid` and no fill. `fault_level` gives the level that faulted: 4 = five-level top, 3 = VA[47:39], 2, 1, 0 = VA[20:12].
- R6: Bit 7 (page size) set in a present entry read at level 2 ends the walk with `fill_size`=2 (1 GB) and `fill_pfn` = {entry[51:30], VA[29:12]}.
- R7: Bit 7 set in a present entry read at level 1 ends the walk with `fill_size`=1 (2 MB) and `fill_pfn` = {entry[51:21], VA[20:12]}.
- R8: A present entry at level 0 gives `fill_size`=0 (4 KB) and `fill_pfn`=entry[51:12], whatever the value of bit 7. Bit 7 at levels 3 and 4 is ignored, and the entry is followed as a pointer.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and its address is unchanged on the next cycle.
- R10: In four-level mode, VA[56:48] has no effect on any read address or on the result.
- R11: `fill_valid` and `fault_valid` are never 1 together. Each lasts one cycle, and `miss_ready` is 1 on the cycle after either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Translation miss request |
| miss_va | input | VA_W (57) | Virtual address to resolve |
| five_level | input | 1 | 1 = five-level walk, 0 = four-level walk |
| root_frame | input | PA_W-12 (40) | Frame number of the top-level table |
| miss_ready | output | 1 | Walker idle and able to take a miss |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | PA_W (52) | Byte address of the entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry read |
| fill_valid | output | 1 | One-cycle translation fill |
| fill_pfn | output | PA_W-12 (40) | Frame number of the 4 KB page holding the address |
| fill_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| fault_valid | output | 1 | One-cycle walk fault |
| fault_level | output | 3 | Level whose entry was not present |

## Verification
On every cycle the assertions check the request hold rule while memory stalls, that no read is issued while the walker is idle, that fill and fault are mutually exclusive single-cycle pulses, that the size code is legal, and that a walk never makes more reads than its mode allows. The bench scenarios show the rest. They confirm the exact index slice used at each level, the frame composition for huge leaves, that bit 7 is ignored at the pointer-only levels and at the lowest level, that the upper address bits have no effect in four-level mode, and that a miss offered mid-walk leaves the walk unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } ptw_state_e;

  typedef enum logic [1:0] {
    PG_4K = 2'd0,
    PG_2M = 2'd1,
    PG_1G = 2'd2
  } pg_size_e;

  localparam int PRESENT_BIT = 0;
  localparam int HUGE_BIT    = 7;

endpackage

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
  parameter int VA_W  = 57,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int LVL_W = 3
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);
  localparam int NLVL = (VA_W - OFF_W) / IDX_W;

  logic [IDX_W-1:0] cand [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_slice
    assign cand[g] = va[OFF_W + g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (lvl == LVL_W'(i)) idx = cand[i];
    end
  end
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
  import ptw_pkg::*;
#(
  parameter int VA_W  = 57,
  parameter int PFN_W = 40,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12,
  parameter int ENT_W = 64,
  parameter int LVL_W = 3
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VA_W-1:0]  va,
  output logic             present,
  output logic             leaf,
  output pg_size_e         size,
  output logic [PFN_W-1:0] leaf_pfn,
  output logic [PFN_W-1:0] next_frame
);
  localparam int GB_BITS = 2 * IDX_W;

  logic [PFN_W-1:0] keep_va;
  logic [PFN_W-1:0] va_low;

  assign present    = entry[PRESENT_BIT];
  assign next_frame = entry[OFF_W +: PFN_W];
  assign va_low     = PFN_W'(va[OFF_W +: GB_BITS]);

  always_comb begin
    leaf    = 1'b0;
    size    = PG_4K;
    keep_va = '0;
    if (lvl == LVL_W'(0)) begin
      leaf = 1'b1;
    end else if (lvl == LVL_W'(1) && entry[HUGE_BIT]) begin
      leaf    = 1'b1;
      size    = PG_2M;
      keep_va = PFN_W'((1 << IDX_W) - 1);
    end else if (lvl == LVL_W'(2) && entry[HUGE_BIT]) begin
      leaf    = 1'b1;
      size    = PG_1G;
      keep_va = PFN_W'((1 << GB_BITS) - 1);
    end
  end

  assign leaf_pfn = (next_frame & ~keep_va) | (va_low & keep_va);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 57,
  parameter int PA_W  = 52,
  parameter int ENT_W = 64,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  miss_valid,
  input  logic [VA_W-1:0]       miss_va,
  input  logic                  five_level,
  input  logic [PA_W-OFF_W-1:0] root_frame,
  output logic                  miss_ready,
  output logic                  mem_req_valid,
  output logic [PA_W-1:0]       mem_req_addr,
  input  logic                  mem_req_ready,
  input  logic                  mem_rsp_valid,
  input  logic [ENT_W-1:0]      mem_rsp_data,
  output logic                  fill_valid,
  output logic [PA_W-OFF_W-1:0] fill_pfn,
  output logic [1:0]            fill_size,
  output logic                  fault_valid,
  output logic [2:0]            fault_level
);
  localparam int PFN_W  = PA_W - OFF_W;
  localparam int LVL_W  = 3;
  localparam int ENT_SH = $clog2(ENT_W / 8);
  localparam int MAX_RD = (VA_W - OFF_W) / IDX_W;

  ptw_state_e       state_q;
  logic [VA_W-1:0]  va_q;
  logic [LVL_W-1:0] lvl_q;
  logic             five_q;
  logic [PA_W-1:0]  addr_q;
  logic [PFN_W-1:0] pfn_q;
  pg_size_e         size_q;
  logic [2:0]       flvl_q;

  logic [LVL_W-1:0] start_lvl;
  logic [VA_W-1:0]  sel_va;
  logic [LVL_W-1:0] sel_lvl;
  logic [IDX_W-1:0] sel_idx;
  logic             ent_present;
  logic             ent_leaf;
  pg_size_e         ent_size;
  logic [PFN_W-1:0] ent_leaf_pfn;
  logic [PFN_W-1:0] ent_next;

  assign start_lvl = five_level ? LVL_W'(4) : LVL_W'(3);
  assign sel_va    = (state_q == ST_IDLE) ? miss_va   : va_q;
  assign sel_lvl   = (state_q == ST_IDLE) ? start_lvl : (lvl_q - LVL_W'(1));

  ptw_idx_sel #(
    .VA_W (VA_W),
    .IDX_W(IDX_W),
    .OFF_W(OFF_W),
    .LVL_W(LVL_W)
  ) u_idx (
    .va (sel_va),
    .lvl(sel_lvl),
    .idx(sel_idx)
  );

  ptw_entry_dec #(
    .VA_W (VA_W),
    .PFN_W(PFN_W),
    .IDX_W(IDX_W),
    .OFF_W(OFF_W),
    .ENT_W(ENT_W),
    .LVL_W(LVL_W)
  ) u_dec (
    .entry     (mem_rsp_data),
    .lvl       (lvl_q),
    .va        (va_q),
    .present   (ent_present),
    .leaf      (ent_leaf),
    .size      (ent_size),
    .leaf_pfn  (ent_leaf_pfn),
    .next_frame(ent_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      lvl_q   <= '0;
      five_q  <= 1'b0;
      addr_q  <= '0;
      pfn_q   <= '0;
      size_q  <= PG_4K;
      flvl_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (miss_valid) begin
            va_q    <= miss_va;
            five_q  <= five_level;
            lvl_q   <= start_lvl;
            addr_q  <= PA_W'({root_frame, sel_idx, {ENT_SH{1'b0}}});
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_present) begin
              flvl_q  <= lvl_q;
              state_q <= ST_FAULT;
            end else if (ent_leaf) begin
              pfn_q   <= ent_leaf_pfn;
              size_q  <= ent_size;
              state_q <= ST_DONE;
            end else begin
              lvl_q   <= lvl_q - LVL_W'(1);
              addr_q  <= PA_W'({ent_next, sel_idx, {ENT_SH{1'b0}}});
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign miss_ready    = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign fill_valid    = (state_q == ST_DONE);
  assign fill_pfn      = pfn_q;
  assign fill_size     = size_q;
  assign fault_valid   = (state_q == ST_FAULT);
  assign fault_level   = flvl_q;

  // reads issued in the current walk, kept for the bound check
  logic [3:0] rd_cnt_q;
  always_ff @(posedge clk) begin
    if (rst) rd_cnt_q <= '0;
    else if (miss_ready && miss_valid) rd_cnt_q <= '0;
    else if (mem_req_valid && mem_req_ready) rd_cnt_q <= rd_cnt_q + 4'd1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    miss_ready |-> !mem_req_valid); // R2
  AST_READ_BOUND: assert property (@(posedge clk) disable iff (rst)
    rd_cnt_q <= (five_q ? 4'(MAX_RD) : 4'(MAX_RD - 1))); // R4
  AST_FILL_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fill_valid && fault_valid)); // R11
  AST_FILL_PULSE: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (!fill_valid && miss_ready)); // R11
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> (!fault_valid && miss_ready)); // R5
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> (fill_size != 2'd3)); // R6
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int VA_W = 57;
  localparam int PA_W = 52;
  localparam int PFN_W = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic miss_valid = 1'b0;
  logic [VA_W-1:0] miss_va = '0;
  logic five_level = 1'b0;
  logic [PFN_W-1:0] root_frame = 40'h100;
  logic miss_ready, mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [PA_W-1:0] mem_req_addr;
  logic [63:0] mem_rsp_data;
  logic fill_valid, fault_valid;
  logic [PFN_W-1:0] fill_pfn;
  logic [1:0] fill_size;
  logic [2:0] fault_level;

  always #2 clk = ~clk;

  pt_walker u_dut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_va(miss_va),
    .five_level(five_level), .root_frame(root_frame), .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .fill_valid(fill_valid), .fill_pfn(fill_pfn),
    .fill_size(fill_size), .fault_valid(fault_valid), .fault_level(fault_level)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sparse page-table memory
  logic [PA_W-1:0] tbl_a [16];
  logic [63:0]     tbl_d [16];
  int n_tbl = 0;

  function automatic logic [PA_W-1:0] ta(input logic [39:0] frame, input int idx);
    return {frame, 9'(idx), 3'b000};
  endfunction

  task automatic put(input logic [39:0] frame, input int idx, input logic [39:0] tgt, input bit huge);
    tbl_a[n_tbl] = ta(frame, idx);
    tbl_d[n_tbl] = {12'h0, tgt, 4'h0, huge, 6'h0, 1'b1};
    n_tbl++;
  endtask

  function automatic logic [63:0] lookup(input logic [PA_W-1:0] a);
    for (int i = 0; i < n_tbl; i++) if (tbl_a[i] == a) return tbl_d[i];
    return 64'h0;
  endfunction

  // memory model, driven away from the active edge
  int rd_count = 0;
  logic [PA_W-1:0] addr_log [8];
  bit pending = 0;
  bit prev_stall = 0;
  logic [PA_W-1:0] prev_addr = '0;
  logic [PA_W-1:0] pend_addr = '0;

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pending) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = lookup(pend_addr);
      pending = 0;
    end
    if (!rst && prev_stall)
      chk(mem_req_valid && mem_req_addr == prev_addr, "R9", {11'h0, mem_req_addr}, {11'h0, prev_addr});
    if (!rst && (fill_valid || fault_valid))
      chk(!(fill_valid && fault_valid), "R11", {62'h0, fill_valid, fault_valid}, 64'h0);
    mem_req_ready = (cyc % 3) != 0;
    prev_stall = mem_req_valid && !mem_req_ready;
    prev_addr  = mem_req_addr;
    if (mem_req_valid && mem_req_ready) begin
      if (rd_count < 8) addr_log[rd_count] = mem_req_addr;
      rd_count++;
      pending = 1;
      pend_addr = mem_req_addr;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  // result of one walk
  bit r_fill, r_fault;
  logic [PFN_W-1:0] r_pfn;
  logic [1:0] r_size;
  logic [2:0] r_flvl;

  task automatic walk(input bit five, input logic [VA_W-1:0] va, input bit inject, input logic [VA_W-1:0] va2);
    int t;
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    rd_count = 0;
    five_level = five;
    miss_va = va;
    miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    r_fill = 0; r_fault = 0;
    t = 0;
    while (!(fill_valid || fault_valid) && t < 300) begin
      if (inject && t == 2) begin
        miss_va = va2;
        miss_valid = 1'b1;
      end else begin
        miss_valid = 1'b0;
      end
      @(negedge clk);
      t++;
    end
    miss_valid = 1'b0;
    if (t >= 300) chk(0, "walk timeout", t, 0);
    r_fill = fill_valid; r_fault = fault_valid;
    r_pfn = fill_pfn; r_size = fill_size; r_flvl = fault_level;
    @(negedge clk);
    chk(!fill_valid && !fault_valid && miss_ready, "R11 pulse", {61'h0, fill_valid, fault_valid, miss_ready}, 64'h1);
  endtask

  typedef struct packed {
    logic            five;
    logic [VA_W-1:0] va;
    logic [1:0]      kind;   // 0 4K, 1 2M, 2 1G, 3 fault
    logic [2:0]      flvl;
    logic [39:0]     pfn;
    logic [2:0]      nrd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, {9'd0, 9'd1, 9'd2, 9'd3, 9'd5, 12'hABC},        2'd0, 3'd0, 40'h12345, 3'd4}, // R8 4K (bit7 set)
    '{1'b0, {9'd0, 9'd1, 9'd2, 9'd7, 9'h1F, 12'h000},       2'd1, 3'd0, 40'hAB21F, 3'd3}, // R7 2M
    '{1'b0, {9'd0, 9'd1, 9'd4, 9'h155, 9'h0AA, 12'h010},    2'd2, 3'd0, 40'h6AAAA, 3'd2}, // R6 1G
    '{1'b0, {9'd0, 9'd0, 9'd2, 9'd3, 9'd5, 12'h0},          2'd3, 3'd3, 40'h0,     3'd1}, // R5 level3
    '{1'b0, {9'd0, 9'd1, 9'd6, 9'd3, 9'd5, 12'h0},          2'd3, 3'd2, 40'h0,     3'd2}, // R5 level2
    '{1'b0, {9'd0, 9'd1, 9'd2, 9'd8, 9'd5, 12'h0},          2'd3, 3'd1, 40'h0,     3'd3}, // R5 level1
    '{1'b0, {9'd0, 9'd1, 9'd2, 9'd3, 9'd9, 12'h0},          2'd3, 3'd0, 40'h0,     3'd4}, // R5 level0
    '{1'b0, {9'h1FF, 9'd1, 9'd2, 9'd3, 9'd5, 12'hABC},      2'd0, 3'd0, 40'h12345, 3'd4}, // R10 upper bits
    '{1'b0, {9'd0, 9'd2, 9'd2, 9'd3, 9'd5, 12'h0},          2'd0, 3'd0, 40'h12345, 3'd4}, // R8 bit7 at level3
    '{1'b1, {9'd3, 9'd1, 9'd2, 9'd3, 9'd5, 12'h0},          2'd0, 3'd0, 40'h12345, 3'd5}, // R4 five-level
    '{1'b1, {9'd3, 9'd1, 9'd4, 9'd0, 9'd1, 12'h0},          2'd2, 3'd0, 40'h40001, 3'd3}, // R6 five-level 1G
    '{1'b1, {9'd0, 9'd1, 9'd2, 9'd3, 9'd5, 12'h0},          2'd3, 3'd4, 40'h0,     3'd1}, // R5 level4
    '{1'b1, {9'd3, 9'd0, 9'd2, 9'd3, 9'd5, 12'h0},          2'd3, 3'd3, 40'h0,     3'd2}  // R5 level3 in five-level
  };

  initial begin
    logic [PA_W-1:0] v0_log [4];
    put(40'h100, 1, 40'h200, 0);
    put(40'h100, 2, 40'h200, 1);
    put(40'h100, 3, 40'h600, 0);
    put(40'h600, 1, 40'h200, 0);
    put(40'h200, 2, 40'h300, 0);
    put(40'h200, 4, 40'h40000, 1);
    put(40'h300, 3, 40'h400, 0);
    put(40'h300, 7, 40'hAB200, 1);
    put(40'h400, 5, 40'h12345, 1);

    repeat (4) @(negedge clk);
    chk(miss_ready && !mem_req_valid && !fill_valid && !fault_valid, "R1 in reset",
        {60'h0, miss_ready, mem_req_valid, fill_valid, fault_valid}, 64'h8);
    rst = 1'b0;
    @(negedge clk);
    chk(miss_ready && !mem_req_valid && !fill_valid && !fault_valid, "R1 after reset",
        {60'h0, miss_ready, mem_req_valid, fill_valid, fault_valid}, 64'h8);

    for (int i = 0; i < NV; i++) begin
      walk(VECS[i].five, VECS[i].va, 0, '0);
      if (VECS[i].kind == 2'd3) begin
        chk(r_fault && !r_fill, $sformatf("R5 vec%0d fault", i), {62'h0, r_fault, r_fill}, 64'h2);
        chk(r_flvl == VECS[i].flvl, $sformatf("R5 vec%0d level", i), r_flvl, VECS[i].flvl);
      end else begin
        chk(r_fill && !r_fault, $sformatf("R6 R7 R8 vec%0d fill", i), {62'h0, r_fill, r_fault}, 64'h2);
        chk(r_size == VECS[i].kind, $sformatf("R6 R7 R8 vec%0d size", i), r_size, VECS[i].kind);
        chk(r_pfn == VECS[i].pfn, $sformatf("R6 R7 R8 vec%0d pfn", i), r_pfn, VECS[i].pfn);
      end
      chk(rd_count == int'(VECS[i].nrd), $sformatf("R4 vec%0d reads", i), rd_count, VECS[i].nrd);
      if (i == 0) for (int k = 0; k < 4; k++) v0_log[k] = addr_log[k];
      if (i == 7) for (int k = 0; k < 4; k++)
        chk(addr_log[k] == v0_log[k], "R10 address", addr_log[k], v0_log[k]);
    end

    // R3 R4: exact addresses of a four-level walk
    chk(v0_log[0] == 52'h100008, "R3 first read", v0_log[0], 52'h100008);
    chk(v0_log[1] == 52'h200010, "R4 read2", v0_log[1], 52'h200010);
    chk(v0_log[2] == 52'h300018, "R4 read3", v0_log[2], 52'h300018);
    chk(v0_log[3] == 52'h400028, "R4 read4", v0_log[3], 52'h400028);

    // R3 five-level top index from VA[56:48]
    walk(1'b1, {9'd3, 9'd1, 9'd2, 9'd3, 9'd5, 12'h0}, 0, '0);
    chk(addr_log[0] == 52'h100018, "R3 five-level first read", addr_log[0], 52'h100018);
    chk(addr_log[1] == 52'h600008, "R4 five-level read2", addr_log[1], 52'h600008);
    chk(addr_log[4] == 52'h400028, "R4 five-level read5", addr_log[4], 52'h400028);

    // R2: a miss offered mid-walk is ignored
    walk(1'b0, VECS[0].va, 1, VECS[3].va);
    chk(r_fill && r_pfn == 40'h12345, "R2 walk unchanged", r_pfn, 40'h12345);
    chk(rd_count == 4, "R2 read count", rd_count, 4);
    repeat (6) begin
      @(negedge clk);
      chk(!mem_req_valid && miss_ready, "R2 no extra walk", {62'h0, mem_req_valid, miss_ready}, 64'h1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule